// File: doc/BRIEF.md
# Reconfigurable-Precision Signed Array Multiplier

This block is a pipelined two's-complement multiplier for N-bit operands (N defaults to 4). A static precision setting `prec` picks an operand width p between 2 and N. At reduced precision the operands arrive zero-padded: only their low p bits carry the signed value, and there is no sign extension. The block changes which partial products are complemented and where the correction one enters, so the padded operands still give the right signed product. That product is sign-extended to the full 2N-bit output.

Each partial product a[i]·b[j] is assigned to a register group. At precision p, every group of index p or more is held, and so is every accumulation stage past p. The result is read from stage p, so a lower precision gives a shorter latency. For zero-padded operands, the complemented product a[p]·b[0] always evaluates to one. It is kept in group p-1, and at reduced precision it supplies the column-p correction term. At full precision the correction enters as an internal constant bit instead. The precision is meant to change only while the pipeline is empty.

Top module: `bwm_mul`

## Requirements
- R1: With the effective precision p equal to N, `product` equals the signed product of `a` and `b`, both read as N-bit two's-complement numbers, for every operand pair.
- R2: With 2 ≤ p < N, and with `a` and `b` zero above bit p-1, `product` equals the signed product of the low p bits of each operand read as p-bit two's complement, for every such pair.
- R3: An operand pair sampled with `in_valid` high on a rising edge produces `out_valid` high for exactly one cycle, p+2 rising edges later. A new pair may be accepted on every cycle.
- R4: Any `prec` value below 2 or above N is treated as p = N.
- R5: While `rst` is high, the next edge clears `out_valid` to 0 and `product` to 0.
- R6: While `out_valid` is low, `product` keeps the value of the last valid result (0 after reset).
- R7: Partial-product registers whose group index (the larger of i and j, except that a[i]·b[0] for i>0 is in group i-1) is p or more are not loaded. Accumulation stages above p are not loaded either. After the pipeline drains, a change of precision gives correct results with no residue from the held registers.
- R8: For p < N, the bits of a valid `product` from bit 2p-1 upward are all equal.
- R9: The product of the most negative p-bit value with itself, +2^(2p-2), is returned correctly at every precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prec | input | $clog2(N+1) | Operand precision p; values outside 2..N select N |
| in_valid | input | 1 | Operand pair present this cycle |
| a | input | N | Multiplicand, zero-padded above bit p-1 |
| b | input | N | Multiplier, zero-padded above bit p-1 |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 2N | Signed product, sign-extended from bit 2p-1 |

## Verification
In a single cycle, one stage can add in a group whose complemented products carry a sign-related term while the correction one from the padded bit lands in the same column. The case of both operands at their most negative value loads that column hardest, and the bench drives it at every precision. Operands stream back to back, with a gap now and then, so a result leaves the pipeline in the same cycle that a new pair enters. A behavioural reference with a per-cycle expectation of `out_valid` and `product` checks both the emitted value and the hold behaviour during the gaps.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef enum logic {
        PP_TRUE = 1'b0,
        PP_INV  = 1'b1
    } pp_pol_e;

    // Precision outside 2..n falls back to the full width.
    function automatic int eff_prec(input int p, input int n);
        return (p < 2 || p > n) ? n : p;
    endfunction

    // Register group of partial product a[i]*b[j].
    function automatic int grp_of(input int i, input int j);
        if (j == 0 && i > 0) return i - 1;
        return (i > j) ? i : j;
    endfunction

    // Complement when exactly one index lies at or above the sign position.
    function automatic pp_pol_e pol_of(input int i, input int j, input int p);
        return ((i >= p - 1) != (j >= p - 1)) ? PP_INV : PP_TRUE;
    endfunction

endpackage

// File: rtl/bwm_ppbank.sv
module bwm_ppbank
    import bwm_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [PW-1:0]  prec,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic           vld_q,
    output logic [N*N-1:0] pp_q,
    output logic [N-1:0]   grp_en,
    output logic           cin
);
    logic [N*N-1:0] pp_d;

    always_comb begin
        int p;
        logic prod;
        p = eff_prec(int'(prec), N);
        cin = (p == N);
        for (int g = 0; g < N; g++) grp_en[g] = (g < p);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                prod = a[i] & b[j];
                pp_d[i*N+j] = (pol_of(i, j, p) == PP_INV) ? ~prod : prod;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pp_q  <= '0;
        end else begin
            vld_q <= in_valid;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (grp_en[grp_of(i, j)]) pp_q[i*N+j] <= pp_d[i*N+j];
        end
    end
endmodule

// File: rtl/bwm_stage.sv
module bwm_stage
    import bwm_pkg::*;
#(
    parameter int N = 4,
    parameter int S = 1,
    localparam int W = 2 * N
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   grp_en,
    input  logic           cin,
    input  logic           in_vld,
    input  logic [W-1:0]   in_acc,
    input  logic [N*N-1:0] in_pp,
    output logic           out_vld,
    output logic [W-1:0]   out_acc,
    output logic [N*N-1:0] out_pp
);
    logic [W-1:0] sum;

    // Add the bits of group S-1; the last stage also takes the constant one.
    always_comb begin
        sum = in_acc;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (grp_of(i, j) == S - 1 && in_pp[i*N+j])
                    sum = sum + (W'(1) << (i + j));
        if (S == N && cin) sum = sum + (W'(1) << N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_acc <= '0;
            out_pp  <= '0;
        end else begin
            out_vld <= in_vld;
            if (grp_en[S-1]) out_acc <= sum;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (grp_of(i, j) >= S && grp_en[grp_of(i, j)])
                        out_pp[i*N+j] <= in_pp[i*N+j];
        end
    end
endmodule

// File: rtl/bwm_outsel.sv
module bwm_outsel
    import bwm_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 3,
    localparam int W = 2 * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] prec,
    input  logic [N:0]    vld_all,
    input  logic [W-1:0]  acc_all [0:N],
    output logic          out_valid,
    output logic [W-1:0]  product
);
    logic         sel_vld;
    logic [W-1:0] sel_acc;
    logic [W-1:0] ext;

    // Pick stage p, complement bit 2p-1 and extend it upward.
    always_comb begin
        int p;
        p = eff_prec(int'(prec), N);
        sel_vld = vld_all[p];
        sel_acc = acc_all[p];
        for (int k = 0; k < W; k++)
            ext[k] = (k < 2*p - 1) ? sel_acc[k] : ~sel_acc[2*p-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= sel_vld;
            if (sel_vld) product <= ext;
        end
    end
endmodule

// File: rtl/bwm_mul.sv
module bwm_mul
    import bwm_pkg::*;
#(
    parameter int N = 4,
    localparam int PW = $clog2(N + 1),
    localparam int W  = 2 * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] prec,
    input  logic          in_valid,
    input  logic [N-1:0]  a,
    input  logic [N-1:0]  b,
    output logic          out_valid,
    output logic [W-1:0]  product
);
    logic [N:0]     vld_all;
    logic [W-1:0]   acc_all [0:N];
    logic [N*N-1:0] pp_bus  [0:N];
    logic [N-1:0]   grp_en;
    logic           cin;
    logic [N*W-1:0] acc_flat;

    bwm_ppbank #(.N(N), .PW(PW)) u_bank (
        .clk(clk), .rst(rst), .prec(prec), .in_valid(in_valid),
        .a(a), .b(b), .vld_q(vld_all[0]), .pp_q(pp_bus[0]),
        .grp_en(grp_en), .cin(cin)
    );

    assign acc_all[0] = '0;

    for (genvar s = 1; s <= N; s++) begin : g_stage
        bwm_stage #(.N(N), .S(s)) u_stage (
            .clk(clk), .rst(rst), .grp_en(grp_en), .cin(cin),
            .in_vld(vld_all[s-1]), .in_acc(acc_all[s-1]), .in_pp(pp_bus[s-1]),
            .out_vld(vld_all[s]), .out_acc(acc_all[s]), .out_pp(pp_bus[s])
        );
        assign acc_flat[(s-1)*W +: W] = acc_all[s];
    end

    bwm_outsel #(.N(N), .PW(PW)) u_out (
        .clk(clk), .rst(rst), .prec(prec), .vld_all(vld_all),
        .acc_all(acc_all), .out_valid(out_valid), .product(product)
    );
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk
    import bwm_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 3,
    parameter int W  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [PW-1:0]  prec,
    input logic           out_valid,
    input logic [W-1:0]   product,
    input logic [N*N-1:0] pp0,
    input logic [N*N-1:0] pp_end,
    input logic [N*W-1:0] acc_flat
);
    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0 && pp_end == '0));

    // R6
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(product));

    for (genvar i = 0; i < N; i++) begin : g_pi
        for (genvar j = 0; j < N; j++) begin : g_pj
            // R7
            pp_gate_chk: assert property (@(posedge clk) disable iff (rst)
                (grp_of(i, j) >= eff_prec(int'($past(prec)), N)) |-> $stable(pp0[i*N+j]));
        end
    end

    for (genvar s = 1; s <= N; s++) begin : g_as
        // R7
        acc_gate_chk: assert property (@(posedge clk) disable iff (rst)
            (s > eff_prec(int'($past(prec)), N)) |-> $stable(acc_flat[(s-1)*W +: W]));
    end

    for (genvar q = 2; q < N; q++) begin : g_sx
        // R8
        sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && eff_prec(int'($past(prec)), N) == q)
            |-> (&product[W-1:2*q-1] || ~|product[W-1:2*q-1]));
    end
endmodule

bind bwm_mul bwm_chk #(.N(N), .PW(PW), .W(W)) u_chk (
    .clk(clk), .rst(rst), .prec(prec), .out_valid(out_valid),
    .product(product), .pp0(pp_bus[0]), .pp_end(pp_bus[N]), .acc_flat(acc_flat)
);

// File: tb/tb_bwm_mul.sv
module tb_bwm_mul;
    localparam int N  = 4;
    localparam int PW = $clog2(N + 1);
    localparam int W  = 2 * N;
    localparam int RING = 1024;

    logic          clk = 1'b0;
    logic          rst;
    logic [PW-1:0] prec;
    logic          in_valid;
    logic [N-1:0]  a, b;
    logic          out_valid;
    logic [W-1:0]  product;

    bwm_mul #(.N(N)) dut (
        .clk(clk), .rst(rst), .prec(prec), .in_valid(in_valid),
        .a(a), .b(b), .out_valid(out_valid), .product(product)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit           exp_v [0:RING-1];
    logic [W-1:0] exp_p [0:RING-1];
    int           exp_q [0:RING-1];
    string        exp_t [0:RING-1];
    logic [W-1:0] last_p = '0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_mul(input int x, input int y, input int p);
        longint xv, yv;
        xv = x % (1 << p);
        yv = y % (1 << p);
        if (xv >= (1 << (p - 1))) xv -= (1 << p);
        if (yv >= (1 << (p - 1))) yv -= (1 << p);
        return W'(xv * yv);
    endfunction

    task automatic step(input bit v, input int x, input int y, input int pq, input string tag);
        int idx, pe, slot;
        @(negedge clk);
        cyc++;
        idx = cyc % RING;
        if (exp_v[idx]) begin
            chk(out_valid === 1'b1, "R3", W'(out_valid), W'(1));
            chk(product === exp_p[idx], exp_t[idx], product, exp_p[idx]);
            if (exp_q[idx] < N) begin
                bit same;
                same = 1'b1;
                for (int k = 2*exp_q[idx]-1; k < W; k++)
                    if (product[k] !== product[W-1]) same = 1'b0;
                chk(same, "R8", product, exp_p[idx]);
            end
            last_p = exp_p[idx];
            exp_v[idx] = 1'b0;
        end else begin
            chk(out_valid === 1'b0, "R3", W'(out_valid), W'(0));
            chk(product === last_p, "R6", product, last_p);
        end
        in_valid = v;
        a = N'(x);
        b = N'(y);
        prec = PW'(pq);
        if (v) begin
            pe = (pq < 2 || pq > N) ? N : pq;
            slot = (cyc + pe + 2) % RING;
            exp_v[slot] = 1'b1;
            exp_p[slot] = ref_mul(x, y, pe);
            exp_q[slot] = pe;
            exp_t[slot] = tag;
        end
    endtask

    task automatic drain(input int pq);
        for (int k = 0; k < N + 4; k++) step(1'b0, 0, 0, pq, "R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < RING; k++) begin
            exp_v[k] = 1'b0;
            exp_p[k] = '0;
            exp_q[k] = N;
            exp_t[k] = "";
        end
        rst = 1'b1;
        in_valid = 1'b0;
        a = '0;
        b = '0;
        prec = PW'(N);
        repeat (4) @(negedge clk);
        chk(out_valid === 1'b0, "R5", W'(out_valid), W'(0));
        chk(product === '0, "R5", product, '0);
        rst = 1'b0;

        // Exhaustive sweep at each legal precision, streaming with gaps
        for (int p = N; p >= 2; p--) begin
            int n = 0;
            for (int x = 0; x < (1 << p); x++) begin
                for (int y = 0; y < (1 << p); y++) begin
                    string tag;
                    if (x == (1 << (p - 1)) && y == (1 << (p - 1))) tag = "R9";
                    else if (p == N) tag = "R1";
                    else tag = "R2";
                    step(1'b1, x, y, p, tag);
                    n++;
                    if (n % 7 == 0) step(1'b0, 0, 0, p, "R6");
                end
            end
            drain(p);
        end

        // Out-of-range precision codes fall back to full width
        for (int x = 0; x < (1 << N); x += 3) step(1'b1, x, (1 << N) - 1 - x, 0, "R4");
        drain(0);
        for (int x = 0; x < (1 << N); x += 5) step(1'b1, x, x ^ 5, 1, "R4");
        drain(1);
        for (int x = 0; x < (1 << N); x += 4) step(1'b1, x, 1 << (N - 1), (1 << PW) - 1, "R4");
        drain((1 << PW) - 1);

        // Low precision leaves stale held registers; full precision must ignore them
        for (int x = 0; x < 4; x++) step(1'b1, x, 3 - x, 2, "R2");
        drain(2);
        step(1'b1, (1 << N) - 3, 5, N, "R7");
        step(1'b1, 1 << (N - 1), (1 << N) - 1, N, "R7");
        drain(N);
        for (int x = 0; x < 8; x++) step(1'b1, x, 7 - x, 3, "R2");
        drain(3);
        step(1'b1, (1 << N) - 1, (1 << N) - 1, N, "R7");
        drain(N);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule